// File: doc/BRIEF.md
# Byte-Wide Handshaked Link Port with Word Packing

This block joins two processors over a point-to-point path that carries one byte at a time. At run time the port is set either to send or to receive. A sending port splits 32-bit or 48-bit core words into bytes and puts them on the link, least significant byte first. A receiving port puts arriving bytes back together into words for the core. Each byte is marked by one toggle of the link clock line. The receiving end controls the pace with an acknowledge line that it holds high while it has room.

Each direction has two word stores. On the send side these are a holding register that the core writes and a shift register that empties onto the link. On the receive side they are an assembly register and a register the core can read. The core side uses a valid/ready word interface. A buffer-empty flag on the send side asks the core for the next word. A buffer-full flag on the receive side reports that a word has arrived. Changing the direction or the word size throws away a word that is only partly packed.

Top module: `link_port`

## Requirements
- R1: After reset, rx_valid_o and rx_full_o are 0, tx_empty_o is 1, and lk_clk_o and lk_data_o are 0.
- R2: With pack48_i=0 a word is 4 bytes. The transmitter sends bits [7:0] first and [31:24] last. The receiver returns the 4 bytes as bits [31:0] in arrival order, with bits [47:32] zero.
- R3: With pack48_i=1 a word is 6 bytes, sent and assembled least significant byte first, covering bits [47:0].
- R4: Each transmitted byte is one toggle of lk_clk_o, with lk_data_o already valid. A toggle happens only when lk_ack_i was high at that clock edge. Two toggles are always separated by at least one clock without a toggle.
- R5: In receive mode (dir_tx_i=0), lk_ack_o is low exactly when the core register is full and a complete second word is waiting. One pop in that state raises lk_ack_o on the next cycle. In transmit mode lk_ack_o is 0.
- R6: rx_valid_o and rx_full_o go high when a complete word moves into the core register. They stay high with rx_data_o stable until a cycle with rx_ready_i=1 pops it.
- R7: A word is accepted on tx_data_i when tx_valid_i and tx_ready_o are both high. tx_empty_o is 0 while the holding register has a word waiting behind a word that is being sent.
- R8: A change of dir_tx_i or pack48_i throws away a partly packed word in either direction. Bytes received before the change are lost. A partly sent word sends no further bytes.
- R9: In receive mode tx_ready_o is 0 and lk_clk_o does not toggle. In transmit mode toggles on lk_clk_i are ignored and no received word appears.
- R10: The receiver stores two complete words without a pop and loses neither; they leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_tx_i | input | 1 | 1 selects transmit, 0 selects receive |
| pack48_i | input | 1 | 1 selects 48-bit words, 0 selects 32-bit words |
| tx_data_i | input | 48 | Word to send |
| tx_valid_i | input | 1 | tx_data_i is valid |
| tx_ready_o | output | 1 | Holding register can accept a word |
| tx_empty_o | output | 1 | Transmit holding register empty |
| rx_data_o | output | 48 | Received word |
| rx_valid_o | output | 1 | rx_data_o holds a word |
| rx_ready_i | input | 1 | Core takes the received word |
| rx_full_o | output | 1 | Receive core register full |
| lk_data_o | output | 8 | Link byte driven when sending |
| lk_clk_o | output | 1 | Link clock, toggles once per byte sent |
| lk_ack_i | input | 1 | Acknowledge from the far receiver |
| lk_data_i | input | 8 | Link byte from the far sender |
| lk_clk_i | input | 1 | Link clock from the far sender |
| lk_ack_o | output | 1 | Acknowledge to the far sender |

## Verification
The receive-side overrun assertion assumes that the far sender obeys the same rules as this port: it toggles lk_clk_i only while lk_ack_o is high, and never on two clocks in a row. The bench's link-side sender waits for the acknowledge before every byte and then leaves two idle clocks. The link inputs are taken to be synchronous to clk_i, as in a loopback between two ports on the same clock. The bench changes them only on falling edges. The direction and size inputs change only while the link is quiet, apart from the deliberate mid-word changes in the discard tests.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef struct packed {
    logic tx;
    logic p48;
  } lp_mode_t;
endpackage

// File: rtl/lp_mode.sv
module lp_mode
  import lp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_tx_i,
  input  logic pack48_i,
  output logic flush_o
);
  lp_mode_t mode_d, mode_q;

  assign mode_d = '{tx: dir_tx_i, p48: pack48_i};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) mode_q <= '0;
    else         mode_q <= mode_d;

  assign flush_o = (mode_d != mode_q);
endmodule

// File: rtl/lp_tx.sv
module lp_tx #(
  parameter int BYTE_W  = 8,
  parameter int LONG_W  = 48,
  parameter int SHORT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              p48_i,
  input  logic              flush_i,
  input  logic [LONG_W-1:0] wdata_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic              empty_o,
  input  logic              ack_i,
  output logic [BYTE_W-1:0] ldat_o,
  output logic              lclk_o
);
  localparam int LONG_N  = LONG_W / BYTE_W;
  localparam int SHORT_N = SHORT_W / BYTE_W;
  localparam int CNT_W   = $clog2(LONG_N);
  localparam logic [CNT_W-1:0] LAST_L = CNT_W'(LONG_N - 1);
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(SHORT_N - 1);

  logic [LONG_W-1:0] hold_q, shf_q;
  logic              hold_full_q, busy_q, gap_q, lclk_q;
  logic [CNT_W-1:0]  idx_q;
  logic [BYTE_W-1:0] ldat_q;
  logic [CNT_W-1:0]  last_idx;
  logic              push, load, send;

  assign last_idx = p48_i ? LAST_L : LAST_S;
  assign wready_o = en_i && !hold_full_q;
  assign empty_o  = !hold_full_q;
  assign push     = wvalid_i && wready_o;
  assign load     = en_i && !flush_i && !busy_q && hold_full_q;
  // gap_q enforces one idle clock so the far ack has time to drop
  assign send     = en_i && !flush_i && busy_q && ack_i && !gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
    end else if (push) begin
      hold_q      <= wdata_i;
      hold_full_q <= 1'b1;
    end else if (load) begin
      hold_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shf_q  <= '0;
      busy_q <= 1'b0;
      idx_q  <= '0;
      ldat_q <= '0;
      lclk_q <= 1'b0;
      gap_q  <= 1'b0;
    end else begin
      gap_q <= send;
      if (flush_i) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else if (load) begin
        shf_q  <= hold_q;
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (send) begin
        ldat_q <= shf_q[BYTE_W-1:0];
        shf_q  <= shf_q >> BYTE_W;
        lclk_q <= ~lclk_q;
        idx_q  <= idx_q + 1'b1;
        if (idx_q == last_idx) busy_q <= 1'b0;
      end
    end
  end

  assign ldat_o = ldat_q;
  assign lclk_o = lclk_q;

  // R4: a toggle only follows an edge at which ack was high
  a_r4_ack_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lclk_q) |-> $past(ack_i));
  // R4: never two toggles back to back
  a_r4_pacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lclk_q) |=> $stable(lclk_q));
  // R9: no toggle unless transmit was selected
  a_r9_rx_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lclk_q) |-> $past(en_i));
  // R7: a waiting word stays until the shifter takes it
  a_r7_hold_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_full_q && busy_q) |=> hold_full_q);
endmodule

// File: rtl/lp_rx.sv
module lp_rx #(
  parameter int BYTE_W  = 8,
  parameter int LONG_W  = 48,
  parameter int SHORT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              p48_i,
  input  logic              flush_i,
  input  logic [BYTE_W-1:0] ldat_i,
  input  logic              lclk_i,
  output logic              ack_o,
  output logic [LONG_W-1:0] rdata_o,
  output logic              rvalid_o,
  input  logic              rready_i
);
  localparam int LONG_N  = LONG_W / BYTE_W;
  localparam int SHORT_N = SHORT_W / BYTE_W;
  localparam int CNT_W   = $clog2(LONG_N);
  localparam logic [CNT_W-1:0] LAST_L = CNT_W'(LONG_N - 1);
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(SHORT_N - 1);

  logic              lclk_q, asm_full_q, hold_full_q;
  logic [LONG_W-1:0] asm_q, hold_q;
  logic [CNT_W-1:0]  cnt_q, last_idx;
  logic              edge_seen, pop, move;

  assign last_idx  = p48_i ? LAST_L : LAST_S;
  assign edge_seen = en_i && (lclk_i != lclk_q);
  assign pop       = rready_i && hold_full_q;
  assign move      = asm_full_q && (!hold_full_q || pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lclk_q     <= 1'b0;
      asm_q      <= '0;
      asm_full_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      lclk_q <= lclk_i;
      if (move) asm_full_q <= 1'b0;
      if (flush_i) begin
        cnt_q <= '0;
      end else if (edge_seen) begin
        if (cnt_q == '0) asm_q <= LONG_W'(ldat_i);
        else             asm_q[cnt_q*BYTE_W +: BYTE_W] <= ldat_i;
        if (cnt_q == last_idx) begin
          cnt_q      <= '0;
          asm_full_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
    end else if (move) begin
      hold_q      <= asm_q;
      hold_full_q <= 1'b1;
    end else if (pop) begin
      hold_full_q <= 1'b0;
    end
  end

  assign ack_o    = en_i && !(hold_full_q && asm_full_q);
  assign rdata_o  = hold_q;
  assign rvalid_o = hold_full_q;

  // R10: a byte never arrives while a finished word is still in assembly
  a_r10_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_seen |-> !asm_full_q);
  // R6: core word holds until popped
  a_r6_word_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_full_q && !rready_i) |=> (hold_full_q && $stable(hold_q)));
endmodule

// File: rtl/link_port.sv
module link_port #(
  parameter int BYTE_W  = 8,
  parameter int LONG_W  = 48,
  parameter int SHORT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_tx_i,
  input  logic              pack48_i,
  input  logic [LONG_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              tx_empty_o,
  output logic [LONG_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              rx_full_o,
  output logic [BYTE_W-1:0] lk_data_o,
  output logic              lk_clk_o,
  input  logic              lk_ack_i,
  input  logic [BYTE_W-1:0] lk_data_i,
  input  logic              lk_clk_i,
  output logic              lk_ack_o
);
  logic flush;
  logic rx_valid;

  lp_mode i_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dir_tx_i(dir_tx_i),
    .pack48_i(pack48_i),
    .flush_o (flush)
  );

  lp_tx #(.BYTE_W(BYTE_W), .LONG_W(LONG_W), .SHORT_W(SHORT_W)) i_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (dir_tx_i),
    .p48_i   (pack48_i),
    .flush_i (flush),
    .wdata_i (tx_data_i),
    .wvalid_i(tx_valid_i),
    .wready_o(tx_ready_o),
    .empty_o (tx_empty_o),
    .ack_i   (lk_ack_i),
    .ldat_o  (lk_data_o),
    .lclk_o  (lk_clk_o)
  );

  lp_rx #(.BYTE_W(BYTE_W), .LONG_W(LONG_W), .SHORT_W(SHORT_W)) i_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (!dir_tx_i),
    .p48_i   (pack48_i),
    .flush_i (flush),
    .ldat_i  (lk_data_i),
    .lclk_i  (lk_clk_i),
    .ack_o   (lk_ack_o),
    .rdata_o (rx_data_o),
    .rvalid_o(rx_valid),
    .rready_i(rx_ready_i)
  );

  assign rx_valid_o = rx_valid;
  assign rx_full_o  = rx_valid;

  // R5: a pop while stalled reopens the link next cycle
  a_r5_ack_recovers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_tx_i && !lk_ack_o && rx_ready_i) |=> (lk_ack_o || dir_tx_i));
  // R5: no acknowledge while transmitting
  a_r5_ack_tx_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_tx_i |-> !lk_ack_o);
endmodule

// File: tb/test_link_port.sv
module test_link_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_tx = 1'b0, pack48 = 1'b0;
  logic [47:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, tx_empty;
  logic [47:0] rx_data;
  logic        rx_valid, rx_ready = 1'b0, rx_full;
  logic [7:0]  lk_data_o, lk_data_i = '0;
  logic        lk_clk_o, lk_ack_i = 1'b0, lk_clk_i = 1'b0, lk_ack_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  link_port i_link_port (
    .clk_i(clk), .rst_ni(rst_n), .dir_tx_i(dir_tx), .pack48_i(pack48),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .tx_empty_o(tx_empty), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .rx_ready_i(rx_ready), .rx_full_o(rx_full), .lk_data_o(lk_data_o),
    .lk_clk_o(lk_clk_o), .lk_ack_i(lk_ack_i), .lk_data_i(lk_data_i),
    .lk_clk_i(lk_clk_i), .lk_ack_o(lk_ack_o)
  );

  // link-side monitor: collects transmitted bytes, checks spacing
  logic [7:0] rxq[$];
  logic       mon_prev = 1'b0;
  int         cyc = 0, last_tog = -10, gap_err = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n && lk_clk_o != mon_prev) begin
      rxq.push_back(lk_data_o);
      if (cyc - last_tog < 2) gap_err++;
      last_tog = cyc;
    end
    mon_prev = lk_clk_o;
  end

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    while (!lk_ack_o) @(negedge clk);
    lk_data_i = b;
    lk_clk_i  = ~lk_clk_i;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_word(input logic [47:0] w, input int n);
    for (int i = 0; i < n; i++) send_byte(w[i*8 +: 8]);
    repeat (2) @(negedge clk);
  endtask

  task automatic pop_word;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic push_word(input logic [47:0] w);
    while (!tx_ready) @(negedge clk);
    tx_data  = w;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_bytes(input int n);
    for (int i = 0; i < 200 && rxq.size() < n; i++) @(negedge clk);
  endtask

  task automatic set_mode(input logic d, input logic p);
    dir_tx = d;
    pack48 = p;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(rx_valid == 0 && rx_full == 0, "R1 rx flags", {rx_valid, rx_full}, 0);
    chk(tx_empty == 1, "R1 tx_empty", tx_empty, 1);
    chk(lk_clk_o == 0 && lk_data_o == 0, "R1 link out", {lk_clk_o, lk_data_o}, 0);
  endtask

  task automatic t_rx32;
    set_mode(0, 0);
    send_word(48'h0000_A1B2_C3D4, 4);
    chk(rx_valid && rx_full, "R6 rx word flagged", {rx_valid, rx_full}, 2'b11);
    chk(rx_data == 48'h0000_A1B2_C3D4, "R2 rx 32-bit order", rx_data, 48'h0000_A1B2_C3D4);
    repeat (3) @(negedge clk);
    chk(rx_valid && rx_data == 48'h0000_A1B2_C3D4, "R6 rx held", rx_data, 48'h0000_A1B2_C3D4);
    pop_word();
    chk(!rx_valid && !rx_full, "R6 rx pop clears", rx_valid, 0);
  endtask

  task automatic t_rx48;
    set_mode(0, 1);
    send_word(48'h1122_3344_5566, 6);
    chk(rx_valid && rx_data == 48'h1122_3344_5566, "R3 rx 48-bit order", rx_data, 48'h1122_3344_5566);
    pop_word();
  endtask

  task automatic t_rx_double;
    set_mode(0, 0);
    send_word(48'h0000_0101_0202, 4);
    send_word(48'h0000_0303_0404, 4);
    chk(lk_ack_o == 0, "R5 ack low when both full", lk_ack_o, 0);
    chk(rx_data == 48'h0000_0101_0202, "R10 first word kept", rx_data, 48'h0000_0101_0202);
    pop_word();
    chk(lk_ack_o == 1, "R5 ack back after pop", lk_ack_o, 1);
    chk(rx_valid && rx_data == 48'h0000_0303_0404, "R10 second word kept", rx_data, 48'h0000_0303_0404);
    pop_word();
    chk(!rx_valid, "R10 drained", rx_valid, 0);
  endtask

  task automatic t_rx_flush;
    set_mode(0, 0);
    send_byte(8'hEE);
    send_byte(8'hDD);
    set_mode(0, 1);
    set_mode(0, 0);
    send_word(48'h0000_5A6B_7C8D, 4);
    chk(rx_valid && rx_data == 48'h0000_5A6B_7C8D, "R8 rx partial dropped", rx_data, 48'h0000_5A6B_7C8D);
    pop_word();
    repeat (4) @(negedge clk);
    chk(!rx_valid, "R8 no stray word", rx_valid, 0);
  endtask

  task automatic t_tx32;
    rxq.delete();
    lk_ack_i = 1'b1;
    set_mode(1, 0);
    push_word(48'hFFFF_0A0B_0C0D);
    wait_bytes(4);
    repeat (6) @(negedge clk);
    chk(rxq.size() == 4, "R2 tx byte count", rxq.size(), 4);
    chk({rxq[3], rxq[2], rxq[1], rxq[0]} == 32'h0A0B_0C0D, "R2 tx 32-bit order",
        {rxq[3], rxq[2], rxq[1], rxq[0]}, 32'h0A0B_0C0D);
    chk(gap_err == 0, "R4 tx pacing", gap_err, 0);
  endtask

  task automatic t_tx48;
    rxq.delete();
    set_mode(1, 1);
    push_word(48'hA0A1_A2A3_A4A5);
    wait_bytes(6);
    repeat (6) @(negedge clk);
    chk(rxq.size() == 6, "R3 tx byte count", rxq.size(), 6);
    chk({rxq[5], rxq[4], rxq[3], rxq[2], rxq[1], rxq[0]} == 48'hA0A1_A2A3_A4A5, "R3 tx 48-bit order",
        {rxq[5], rxq[4], rxq[3], rxq[2], rxq[1], rxq[0]}, 48'hA0A1_A2A3_A4A5);
  endtask

  task automatic t_tx_ack;
    rxq.delete();
    set_mode(1, 0);
    lk_ack_i = 1'b0;
    push_word(48'h0000_1111_2222);
    push_word(48'h0000_3333_4444);
    repeat (20) @(negedge clk);
    chk(rxq.size() == 0, "R4 no send without ack", rxq.size(), 0);
    chk(tx_empty == 0 && tx_ready == 0, "R7 holding full", {tx_empty, tx_ready}, 0);
    lk_ack_i = 1'b1;
    wait_bytes(8);
    repeat (6) @(negedge clk);
    chk(rxq.size() == 8 && {rxq[7], rxq[6], rxq[5], rxq[4], rxq[3], rxq[2], rxq[1], rxq[0]} == 64'h3333_4444_1111_2222,
        "R7 both words sent", {rxq[5], rxq[4], rxq[3], rxq[2], rxq[1], rxq[0]}, 48'h4444_1111_2222);
    chk(tx_empty == 1, "R7 empty after send", tx_empty, 1);
    chk(gap_err == 0, "R4 pacing under stall", gap_err, 0);
  endtask

  task automatic t_tx_flush;
    rxq.delete();
    set_mode(1, 1);
    push_word(48'h9988_7766_5544);
    wait_bytes(2);
    pack48 = 1'b0;
    @(negedge clk);
    pack48 = 1'b1;
    repeat (20) @(negedge clk);
    chk(rxq.size() == 2, "R8 tx partial abandoned", rxq.size(), 2);
    rxq.delete();
    push_word(48'h0102_0304_0506);
    wait_bytes(6);
    repeat (6) @(negedge clk);
    chk(rxq.size() == 6 && {rxq[5], rxq[4], rxq[3], rxq[2], rxq[1], rxq[0]} == 48'h0102_0304_0506,
        "R8 tx restarts clean", {rxq[5], rxq[4], rxq[3], rxq[2], rxq[1], rxq[0]}, 48'h0102_0304_0506);
  endtask

  task automatic t_dir;
    rxq.delete();
    set_mode(0, 0);
    tx_valid = 1'b1;
    tx_data  = 48'h0000_DEAD_BEEF;
    repeat (10) @(negedge clk);
    chk(tx_ready == 0, "R9 tx_ready low in rx", tx_ready, 0);
    tx_valid = 1'b0;
    chk(rxq.size() == 0, "R9 no toggle in rx", rxq.size(), 0);
    set_mode(1, 0);
    chk(rxq.size() == 0, "R9 no stale word sent", rxq.size(), 0);
    for (int i = 0; i < 4; i++) begin
      lk_data_i = 8'h30 + 8'(i);
      lk_clk_i  = ~lk_clk_i;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(rx_valid == 0, "R9 rx ignored in tx", rx_valid, 0);
    chk(lk_ack_o == 0, "R5 ack low in tx", lk_ack_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(lk_ack_o == 1, "R5 ack high in idle rx", lk_ack_o, 1);
    t_rx32();
    t_rx48();
    t_rx_double();
    t_rx_flush();
    t_tx32();
    t_tx48();
    t_tx_ack();
    t_tx_flush();
    t_dir();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule